// File: doc/BRIEF.md
# Time-Division Slot-Table Memory Arbiter

This block decides, once per clock, which of up to fifteen requesters may use a single shared memory port. The service order comes from a table of 64 entries that software loads. Each entry names the client that owns that time slot. A pointer visits one entry per cycle and wraps around after the last one. When the owner of the current entry is requesting, the owner receives the grant. When the owner is idle, the slot is not wasted: the lowest-numbered requesting client receives it. A client that owns no entry at all therefore still receives service whenever the table's owners leave slots unused.

Software fills the table one entry at a time with a single-cycle write that carries a slot number and a client index. Reset gives every client a share of the table, so traffic flows before any entry is written. An entry that holds an index outside the client range acts as an unowned slot and always goes to the fallback winner. The grant comes out as a registered one-hot vector with a separate valid flag. The client count is a parameter, and nine-client and fifteen-client instances are both supported.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `gnt` is all zeros and `gnt_valid` is low.
- R2: If the current entry names a client below `NUM_CLIENTS` and that client's `req` bit is set, the next `gnt` is the one-hot vector with only that client's bit set.
- R3: If the owner's `req` bit is clear and some other `req` bit is set, the next `gnt` selects the lowest-numbered requesting client (bit 0 has the highest priority).
- R4: If `req` is all zeros, the next `gnt` is zero and `gnt_valid` is low.
- R5: The slot pointer starts at entry 0 after reset, moves forward by one entry every cycle whatever the inputs are, and returns to entry 0 after entry 63.
- R6: After reset, and before any write, entry i holds client (i mod `NUM_CLIENTS`).
- R7: When `cfg_we` is high, entry `cfg_slot` takes the value `cfg_client` at that clock edge. The arbitration made at that same edge uses the old value, so a write to the entry under the pointer takes effect on the next pass through the table.
- R8: A client that owns no entry is granted in every slot whose owner is idle, provided no lower-numbered client is requesting.
- R9: An entry holding an index of `NUM_CLIENTS` or higher grants only through the fallback rule of R3.
- R10: `gnt` never has more than one bit set, `gnt_valid` is high exactly when `gnt` is non-zero, and a granted client had its `req` bit set at the edge that produced the grant.
- R11: A nine-client instance (`NUM_CLIENTS` = 9) follows R1 to R10 with its 4-bit client field. Written values from 9 to 15 count as out of range for that instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write enable for one table entry |
| cfg_slot | input | $clog2(NUM_SLOTS) | Number of the entry to write |
| cfg_client | input | $clog2(NUM_CLIENTS) | Client index to store in that entry |
| req | input | NUM_CLIENTS | Request bit per client |
| gnt | output | NUM_CLIENTS | Registered one-hot grant |
| gnt_valid | output | 1 | High when a grant is issued this cycle |

## Verification
A grant depends on the request bits and on the entry under the pointer at a rising edge. It appears on `gnt` and `gnt_valid` in the cycle that follows that edge. The bench therefore applies inputs on the falling edge and compares outputs on the next falling edge, one register stage later. A table write changes arbitration only when the pointer next reaches that entry, which is at least one edge after the write. The bench keeps a behavioural model that reads the old entry contents before it applies the write, and checks both the 15-client and the 9-client instance against that model on every cycle.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    // Upper bound on clients handled by the shared helper functions.
    localparam int MAX_CLIENTS = 16;
    localparam int IDX_W       = $clog2(MAX_CLIENTS);

    typedef logic [MAX_CLIENTS-1:0] client_vec_t;
    typedef logic [IDX_W-1:0]       client_idx_t;

    // Where a grant came from in the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_OWNER    = 2'd1,
        SRC_FALLBACK = 2'd2
    } grant_src_e;

    typedef struct packed {
        grant_src_e  src;
        client_vec_t onehot;
    } grant_t;

    // Fixed-priority pick: the lowest set bit wins.
    function automatic client_vec_t lowest_request(client_vec_t r);
        client_vec_t o;
        o = '0;
        for (int i = MAX_CLIENTS - 1; i >= 0; i--) begin
            if (r[i]) begin
                o    = '0;
                o[i] = 1'b1;
            end
        end
        return o;
    endfunction

    // Decode a client index into a one-hot vector.
    function automatic client_vec_t index_to_onehot(client_idx_t idx);
        client_vec_t o;
        o      = '0;
        o[idx] = 1'b1;
        return o;
    endfunction

    // Reset owner of a table entry: spread clients round-robin.
    function automatic int unsigned reset_owner(int unsigned slot, int unsigned n);
        return slot % n;
    endfunction

endpackage

// File: rtl/tdm_slot_table.sv
module tdm_slot_table
    import tdm_arb_pkg::*;
#(
    parameter int NUM_CLIENTS = 15,
    parameter int NUM_SLOTS   = 64,
    parameter int CLIENT_W    = $clog2(NUM_CLIENTS),
    parameter int SLOT_W      = $clog2(NUM_SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic [CLIENT_W-1:0] wr_client,
    input  logic [SLOT_W-1:0]   rd_slot,
    output logic [CLIENT_W-1:0] rd_client
);

    logic [CLIENT_W-1:0] entries [NUM_SLOTS];

    // One register per entry. Each entry has its own reset owner and
    // its own write decode.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_entry
        localparam logic [CLIENT_W-1:0] INIT_OWNER =
            CLIENT_W'(reset_owner(s, NUM_CLIENTS));
        logic [CLIENT_W-1:0] entry_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q <= INIT_OWNER;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                entry_q <= wr_client;
            end
        end

        assign entries[s] = entry_q;
    end

    // Read the current contents. A write at the same edge lands afterwards.
    assign rd_client = entries[rd_slot];

endmodule

// File: rtl/tdm_slot_pointer.sv
module tdm_slot_pointer #(
    parameter int NUM_SLOTS = 64,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] ptr
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ptr_q == LAST_SLOT) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/tdm_grant_select.sv
module tdm_grant_select
    import tdm_arb_pkg::*;
#(
    parameter int NUM_CLIENTS = 15,
    parameter int CLIENT_W    = $clog2(NUM_CLIENTS)
) (
    input  logic [CLIENT_W-1:0]    owner,
    input  logic [NUM_CLIENTS-1:0] req,
    output grant_t                 sel
);

    client_vec_t req_ext;
    client_idx_t owner_idx;
    logic        owner_in_range;
    logic        owner_claims;

    always_comb begin
        req_ext                  = '0;
        req_ext[NUM_CLIENTS-1:0] = req;
    end

    assign owner_idx = IDX_W'(owner);

    // When the client count fills the index field, every code is a
    // real client. Otherwise codes past the count mark an unowned slot.
    if (NUM_CLIENTS == (1 << CLIENT_W)) begin : g_full_range
        assign owner_in_range = 1'b1;
    end else begin : g_partial_range
        localparam logic [CLIENT_W-1:0] LIMIT = CLIENT_W'(NUM_CLIENTS);
        assign owner_in_range = (owner < LIMIT);
    end

    assign owner_claims = owner_in_range && req_ext[owner_idx];

    always_comb begin
        if (owner_claims) begin
            sel.src    = SRC_OWNER;
            sel.onehot = index_to_onehot(owner_idx);
        end else if (|req_ext) begin
            sel.src    = SRC_FALLBACK;
            sel.onehot = lowest_request(req_ext);
        end else begin
            sel.src    = SRC_NONE;
            sel.onehot = '0;
        end
    end

endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter
    import tdm_arb_pkg::*;
#(
    parameter int NUM_CLIENTS = 15,
    parameter int NUM_SLOTS   = 64,
    localparam int CLIENT_W   = $clog2(NUM_CLIENTS),
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [SLOT_W-1:0]      cfg_slot,
    input  logic [CLIENT_W-1:0]    cfg_client,
    input  logic [NUM_CLIENTS-1:0] req,
    output logic [NUM_CLIENTS-1:0] gnt,
    output logic                   gnt_valid
);

    logic [SLOT_W-1:0]      slot_ptr;
    logic [CLIENT_W-1:0]    slot_owner;
    grant_t                 sel;
    logic [NUM_CLIENTS-1:0] gnt_q;
    logic                   gnt_valid_q;

    tdm_slot_pointer #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_pointer (
        .clk (clk),
        .rst (rst),
        .ptr (slot_ptr)
    );

    tdm_slot_table #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .NUM_SLOTS   (NUM_SLOTS)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_slot   (cfg_slot),
        .wr_client (cfg_client),
        .rd_slot   (slot_ptr),
        .rd_client (slot_owner)
    );

    tdm_grant_select #(
        .NUM_CLIENTS (NUM_CLIENTS)
    ) u_select (
        .owner (slot_owner),
        .req   (req),
        .sel   (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q       <= '0;
            gnt_valid_q <= 1'b0;
        end else begin
            gnt_q       <= sel.onehot[NUM_CLIENTS-1:0];
            gnt_valid_q <= (sel.src != SRC_NONE);
        end
    end

    assign gnt       = gnt_q;
    assign gnt_valid = gnt_valid_q;

endmodule

// File: rtl/tdm_arb_checker.sv
module tdm_arb_checker
    import tdm_arb_pkg::*;
#(
    parameter int NUM_CLIENTS = 15,
    parameter int NUM_SLOTS   = 64,
    parameter int CLIENT_W    = $clog2(NUM_CLIENTS),
    parameter int SLOT_W      = $clog2(NUM_SLOTS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CLIENTS-1:0] req,
    input logic [NUM_CLIENTS-1:0] gnt,
    input logic                   gnt_valid,
    input logic [SLOT_W-1:0]      slot_ptr,
    input logic [CLIENT_W-1:0]    slot_owner
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    client_vec_t req_ext;
    client_vec_t gnt_ext;
    client_idx_t owner_idx;
    logic        owner_claims;

    always_comb begin
        req_ext                  = '0;
        req_ext[NUM_CLIENTS-1:0] = req;
        gnt_ext                  = '0;
        gnt_ext[NUM_CLIENTS-1:0] = gnt;
    end

    assign owner_idx    = IDX_W'(slot_owner);
    assign owner_claims = (int'(owner_idx) < NUM_CLIENTS) && req_ext[owner_idx];

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!gnt_valid && (gnt == '0)));                          // R1

    AST_OWNER_WINS: assert property (@(posedge clk) disable iff (rst)
        owner_claims |=> gnt_ext[$past(owner_idx)]);                           // R2

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> (!gnt_valid && (gnt == '0)));                          // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot_ptr == (($past(slot_ptr) == LAST_SLOT) ?
                                       '0 : $past(slot_ptr) + 1'b1)));        // R5

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));                                                        // R10

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        gnt_valid == (gnt != '0));                                             // R10

    AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((gnt & ~$past(req)) == '0));                          // R10

endmodule

bind tdm_slot_arbiter tdm_arb_checker #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .NUM_SLOTS   (NUM_SLOTS)
) u_checker (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .gnt        (gnt),
    .gnt_valid  (gnt_valid),
    .slot_ptr   (slot_ptr),
    .slot_owner (slot_owner)
);

// File: tb/tdm_slot_arbiter_tb_top.sv
module tdm_ref_model #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [5:0]   wslot,
    input  logic [3:0]   wclient,
    input  logic [N-1:0] req,
    output logic [N-1:0] exp_gnt
);
    int tbl [64];
    int ptr = 0;

    always @(posedge clk) begin
        int owner;
        int pick;
        logic [N-1:0] g;
        if (rst) begin
            for (int i = 0; i < 64; i++) tbl[i] = i % N;
            ptr = 0;
            exp_gnt <= '0;
        end else begin
            owner = tbl[ptr];
            g = '0;
            pick = -1;
            if (owner < N) begin
                if (req[owner]) pick = owner;
            end
            if (pick < 0) begin
                for (int i = N - 1; i >= 0; i--) if (req[i]) pick = i;
            end
            if (pick >= 0) g[pick] = 1'b1;
            if (we) tbl[wslot] = int'(wclient);
            ptr = (ptr + 1) % 64;
            exp_gnt <= g;
        end
    end
endmodule

module tdm_slot_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_A = 15;
    localparam int N_B = 9;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           we = 1'b0;
    logic [5:0]     wslot = '0;
    logic [3:0]     wclient = '0;
    logic [N_A-1:0] req_a = '0;
    logic [N_B-1:0] req_b;
    logic [N_A-1:0] gnt_a, exp_a;
    logic [N_B-1:0] gnt_b, exp_b;
    logic           val_a, val_b;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R1";

    assign req_b = req_a[N_B-1:0];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tdm_slot_arbiter #(.NUM_CLIENTS(N_A), .NUM_SLOTS(64)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_slot(wslot), .cfg_client(wclient),
        .req(req_a), .gnt(gnt_a), .gnt_valid(val_a)
    );

    tdm_slot_arbiter #(.NUM_CLIENTS(N_B), .NUM_SLOTS(64)) dut9_i (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_slot(wslot), .cfg_client(wclient),
        .req(req_b), .gnt(gnt_b), .gnt_valid(val_b)
    );

    tdm_ref_model #(.N(N_A)) mdl_a (
        .clk(clk), .rst(rst), .we(we), .wslot(wslot), .wclient(wclient),
        .req(req_a), .exp_gnt(exp_a)
    );

    tdm_ref_model #(.N(N_B)) mdl_b (
        .clk(clk), .rst(rst), .we(we), .wslot(wslot), .wclient(wclient),
        .req(req_b), .exp_gnt(exp_b)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic check_all();
        checks++;
        if (gnt_a !== exp_a || val_a !== (|exp_a)) begin
            fails++;
            $display("FAIL %s (15 clients) t=%0t: gnt=%h valid=%b expected gnt=%h valid=%b",
                     phase, $time, gnt_a, val_a, exp_a, |exp_a);
        end
        checks++;
        if (gnt_b !== exp_b || val_b !== (|exp_b)) begin
            fails++;
            $display("FAIL R11/%s (9 clients) t=%0t: gnt=%h valid=%b expected gnt=%h valid=%b",
                     phase, $time, gnt_b, val_b, exp_b, |exp_b);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R5 watchdog expired: progress=0 expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset, even with every request set
        phase = "R1";
        req_a = '1;
        repeat (3) cyc();
        checks++;
        if (gnt_a !== '0 || val_a !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: gnt=%h valid=%b expected gnt=0 valid=0", gnt_a, val_a);
        end
        rst = 1'b0;

        // R6 / R2 / R5: all requesting, grants follow reset owners across a wrap
        phase = "R6";
        repeat (130) cyc();

        // R3 / R10: random request patterns exercise owner and fallback
        phase = "R3";
        for (int k = 0; k < 200; k++) begin
            req_a = N_A'($urandom) & N_A'($urandom);
            cyc();
        end

        // R4: no requests, no grants
        phase = "R4";
        req_a = '0;
        repeat (10) cyc();

        // R7: fill table with client 2, one write per cycle
        phase = "R7";
        req_a = '1;
        for (int s = 0; s < 64; s++) begin
            we = 1'b1;
            wslot = 6'(s);
            wclient = 4'd2;
            cyc();
        end
        // R7: write the entry under the pointer; takes effect next pass
        we = 1'b1;
        wslot = 6'(mdl_a.ptr);
        wclient = 4'd9;
        cyc();
        we = 1'b0;
        repeat (70) cyc();

        // R8: client 5 owns no entry yet gets idle slots
        phase = "R8";
        req_a = N_A'(1 << 5);
        repeat (70) cyc();
        req_a = N_A'((1 << 5) | (1 << 2));
        repeat (20) cyc();

        // R9: out-of-range indices leave every slot to fallback
        phase = "R9";
        for (int s = 0; s < 64; s++) begin
            we = 1'b1;
            wslot = 6'(s);
            wclient = 4'd15;
            req_a = N_A'($urandom);
            cyc();
        end
        we = 1'b0;
        for (int k = 0; k < 80; k++) begin
            req_a = N_A'($urandom) & N_A'($urandom);
            cyc();
        end

        summary();
        $finish;
    end
endmodule